// File: doc/BRIEF.md
# Descriptor Ring Manager

This block keeps track of two circular lists of descriptors held in local memory for a DMA-style Ethernet MAC. One list carries frames out (transmit) and one carries frames in (receive). Each descriptor takes three consecutive memory words: word 0 is the buffer address, word 1 is the byte size, and word 2 is the status word. Software sets up each list with a base word address and a count register. The count register holds the number of descriptors minus one.

Software and the MAC frame engine pass descriptors back and forth. Software does this with a done strobe. The engine does it with simple handshakes. The block keeps the indices and an occupancy count for each list. It shows software, through one flag per list, whether the current descriptor is free for it. On the receive side it writes the size and status words back to memory. It also raises a memory-available interrupt for transmit and a frame-ready interrupt for receive, each behind its own mask.

Top module: `desc_ring_mgr`

## Requirements
- R1: After reset all indices, occupancy counts, enable bits, mask bits, base addresses and counts are zero. With the count at zero each list has one descriptor. In this state the transmit flag reads 0, the receive flag reads 1, and both interrupts are low.
- R2: The word address of descriptor i, word w, is base + 3*i + w. `tx_desc_addr` gives word 0 of the descriptor at the transmit hardware index. `rx_desc_addr` gives word 0 of the descriptor at the receive hardware index.
- R3: A list holds count+1 descriptors. Its indices wrap to zero after they reach the count. A register write to a list's base or count clears that list's indices and occupancy.
- R4: A transmit done strobe moves the transmit software index forward and hands one descriptor to hardware. The transmit flag reads 1 when all count+1 descriptors are with hardware. A done strobe is ignored while the flag reads 1.
- R5: `tx_req` is high when transmit is enabled and at least one descriptor is with hardware. `tx_ack` together with `tx_req` moves the hardware index forward and returns that descriptor to software.
- R6: `rx_frame` is taken in a cycle where `rx_room` is high. On the next cycle the block writes `rx_size` to word 1. On the cycle after that it writes the status word to word 2, with bit 0 set to `rx_err` and bit 1 set to 1. The descriptor then passes to software. `rx_room` stays low while this write-back is under way, and a write-back that has started always finishes.
- R7: The receive flag reads 0 when at least one filled descriptor is waiting for software. A receive done strobe moves the receive software index forward and frees that descriptor. The strobe is ignored while the flag reads 1. `rx_room` is low when all count+1 descriptors are filled, and `rx_frame` has no effect then.
- R8: `tx_irq` is high when the transmit mask bit is set and the transmit flag is 0. `rx_irq` is high when the receive mask bit is set and the receive flag is 0. Clearing a mask bit holds its interrupt low.
- R9: When a list's enable bit is clear, that list does not move forward. Its done strobes and engine handshakes are ignored, and `tx_req` or `rx_room` stays low. Setting the enable bit again carries on from the indices that were held.
- R10: Register map. Address bit 3 selects the list (0 transmit, 1 receive). Bits 2..0 select the register: 0 base, 1 count, 2 enable (bit 0), 3 mask (bit 0), 4 flag (read only), 5 software index (read only: transmit produce index or receive consume index), 6 done strobe (write only, the data is ignored). Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| tx_req | output | 1 | A transmit descriptor is ready for the engine |
| tx_desc_addr | output | ADDR_W | Word 0 address of the transmit descriptor with hardware |
| tx_ack | input | 1 | The engine has finished the current transmit descriptor |
| rx_room | output | 1 | A receive descriptor is free to fill |
| rx_desc_addr | output | ADDR_W | Word 0 address of the receive descriptor being filled |
| rx_frame | input | 1 | The engine has finished receiving a frame |
| rx_size | input | SIZE_W | Received frame size in bytes |
| rx_err | input | 1 | The received frame is bad |
| mem_we | output | 1 | Descriptor memory write enable |
| mem_addr | output | ADDR_W | Descriptor memory word address |
| mem_wdata | output | DATA_W | Descriptor memory write data |
| tx_irq | output | 1 | Transmit memory-available interrupt |
| rx_irq | output | 1 | Receive frame-ready interrupt |

## Verification
Some rules are checked by the assertions on every cycle:

- no list ever fills past its count or drains when empty;
- indices wrap at the programmed count;
- each write-back issues the size word and then the status word at the next address;
- a disabled list's indices do not change.

Other behaviour needs the bench's scenarios. These cover:

- ignoring done strobes when the list is full or empty;
- the descriptor addresses produced after wrapping;
- clearing a list by rewriting its count;
- resuming after enable is set again;
- the interrupt levels under each mask setting.

// File: rtl/drm_pkg.sv
package drm_pkg;
    // Descriptor layout: three consecutive words
    localparam int DESC_WORDS = 3;
    localparam int WORD_BUF   = 0;
    localparam int WORD_SIZE  = 1;
    localparam int WORD_STAT  = 2;

    // Receive status word bits
    localparam int ST_ERR  = 0;
    localparam int ST_DONE = 1;

    // Register offsets within a ring's window
    localparam logic [2:0] OFF_BASE  = 3'd0;
    localparam logic [2:0] OFF_COUNT = 3'd1;
    localparam logic [2:0] OFF_EN    = 3'd2;
    localparam logic [2:0] OFF_MASK  = 3'd3;
    localparam logic [2:0] OFF_FLAG  = 3'd4;
    localparam logic [2:0] OFF_INDEX = 3'd5;
    localparam logic [2:0] OFF_DONE  = 3'd6;

    typedef enum logic [1:0] {
        WB_IDLE = 2'd0,
        WB_SIZE = 2'd1,
        WB_STAT = 2'd2
    } wb_state_e;

    function automatic logic [31:0] desc_word(logic [31:0] base, logic [31:0] idx,
                                              logic [31:0] w);
        return base + 32'(DESC_WORDS) * idx + w;
    endfunction
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [IDX_W-1:0] count,
    input  logic             fill,
    input  logic             drain,
    output logic [IDX_W-1:0] fill_idx,
    output logic [IDX_W-1:0] drain_idx,
    output logic             full,
    output logic             empty
);
    localparam int OCC_W = IDX_W + 1;

    logic [OCC_W-1:0] occ;
    logic [OCC_W-1:0] depth;

    assign depth = {1'b0, count} + OCC_W'(1);
    assign full  = (occ == depth);
    assign empty = (occ == '0);

    function automatic logic [IDX_W-1:0] step(logic [IDX_W-1:0] i, logic [IDX_W-1:0] lim);
        return (i == lim) ? '0 : i + IDX_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fill_idx  <= '0;
            drain_idx <= '0;
            occ       <= '0;
        end else begin
            if (fill)  fill_idx  <= step(fill_idx, count);
            if (drain) drain_idx <= step(drain_idx, count);
            case ({fill, drain})
                2'b10:   occ <= occ + OCC_W'(1);
                2'b01:   occ <= occ - OCC_W'(1);
                default: occ <= occ;
            endcase
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        fill |-> !full);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        drain |-> !empty);
    p_occ_bound_r3: assert property (@(posedge clk) disable iff (rst)
        occ <= depth);
    p_fill_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (fill && !clear && fill_idx == count) |=> fill_idx == '0);
    p_drain_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (drain && !clear && drain_idx == count) |=> drain_idx == '0);
endmodule

// File: rtl/rx_writeback.sv
module rx_writeback
    import drm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SIZE_W-1:0] size,
    input  logic              err,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done
);
    wb_state_e         st;
    logic [SIZE_W-1:0] size_q;
    logic              err_q;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= WB_IDLE;
            size_q <= '0;
            err_q  <= 1'b0;
            base_q <= '0;
        end else begin
            case (st)
                WB_IDLE: if (start) begin
                    st     <= WB_SIZE;
                    size_q <= size;
                    err_q  <= err;
                    base_q <= desc_addr;
                end
                WB_SIZE: st <= WB_STAT;
                default: st <= WB_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != WB_IDLE);
        mem_we    = busy;
        done      = (st == WB_STAT);
        if (st == WB_SIZE) begin
            mem_addr  = base_q + ADDR_W'(WORD_SIZE);
            mem_wdata = DATA_W'(size_q);
        end else begin
            mem_addr  = base_q + ADDR_W'(WORD_STAT);
            mem_wdata = DATA_W'((1 << ST_DONE) | (int'(err_q) << ST_ERR));
        end
    end

    p_start_idle_r6: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    p_size_then_stat_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !done) |=> (mem_we && done && mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: rtl/desc_ring_mgr.sv
module desc_ring_mgr
    import drm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_req,
    output logic [ADDR_W-1:0] tx_desc_addr,
    input  logic              tx_ack,
    output logic              rx_room,
    output logic [ADDR_W-1:0] rx_desc_addr,
    input  logic              rx_frame,
    input  logic [SIZE_W-1:0] rx_size,
    input  logic              rx_err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              tx_irq,
    output logic              rx_irq
);
    localparam int NRING = 2;
    localparam int TXR   = 0;
    localparam int RXR   = 1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  count;
        logic              en;
        logic              mask;
    } ring_cfg_t;

    ring_cfg_t        cfg [NRING];
    logic [NRING-1:0] clr, done_wr, flag;
    logic [IDX_W-1:0] sw_idx [NRING];
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata;

    for (genvar g = 0; g < NRING; g++) begin : g_cfg
        logic sel;
        assign sel        = reg_wr && (reg_addr[3] == 1'(g));
        assign clr[g]     = sel && (reg_addr[2:0] == OFF_BASE || reg_addr[2:0] == OFF_COUNT);
        assign done_wr[g] = sel && (reg_addr[2:0] == OFF_DONE);
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= '0;
            end else if (sel) begin
                case (reg_addr[2:0])
                    OFF_BASE:  cfg[g].base  <= reg_wdata[ADDR_W-1:0];
                    OFF_COUNT: cfg[g].count <= reg_wdata[IDX_W-1:0];
                    OFF_EN:    cfg[g].en    <= reg_wdata[0];
                    OFF_MASK:  cfg[g].mask  <= reg_wdata[0];
                    default:   ;
                endcase
            end
        end
    end

    // Transmit ring: software fills, engine drains
    logic [IDX_W-1:0] tx_fill_idx, tx_drain_idx;
    logic tx_full, tx_empty, tx_fill, tx_drain;

    assign tx_req   = cfg[TXR].en && !tx_empty;
    assign tx_fill  = done_wr[TXR] && cfg[TXR].en && !tx_full;
    assign tx_drain = tx_ack && tx_req;

    ring_ctrl #(.IDX_W(IDX_W)) u_tx_ring (
        .clk(clk), .rst(rst), .clear(clr[TXR]), .count(cfg[TXR].count),
        .fill(tx_fill), .drain(tx_drain),
        .fill_idx(tx_fill_idx), .drain_idx(tx_drain_idx),
        .full(tx_full), .empty(tx_empty)
    );

    assign tx_desc_addr = ADDR_W'(desc_word(32'(cfg[TXR].base), 32'(tx_drain_idx),
                                            32'(WORD_BUF)));

    // Receive ring: engine fills through write-back, software drains
    logic [IDX_W-1:0] rx_fill_idx, rx_drain_idx;
    logic rx_full, rx_empty, rx_drain, wb_busy, wb_done;

    assign rx_room  = cfg[RXR].en && !rx_full && !wb_busy;
    assign rx_drain = done_wr[RXR] && cfg[RXR].en && !rx_empty;
    assign rx_desc_addr = ADDR_W'(desc_word(32'(cfg[RXR].base), 32'(rx_fill_idx),
                                            32'(WORD_BUF)));

    ring_ctrl #(.IDX_W(IDX_W)) u_rx_ring (
        .clk(clk), .rst(rst), .clear(clr[RXR]), .count(cfg[RXR].count),
        .fill(wb_done), .drain(rx_drain),
        .fill_idx(rx_fill_idx), .drain_idx(rx_drain_idx),
        .full(rx_full), .empty(rx_empty)
    );

    rx_writeback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_rx_wb (
        .clk(clk), .rst(rst), .start(rx_frame && rx_room), .size(rx_size), .err(rx_err),
        .desc_addr(rx_desc_addr), .busy(wb_busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(wb_done)
    );

    // Software-facing flags and indices
    assign flag[TXR]   = tx_full;
    assign flag[RXR]   = rx_empty;
    assign sw_idx[TXR] = tx_fill_idx;
    assign sw_idx[RXR] = rx_drain_idx;

    assign tx_irq = cfg[TXR].mask && !flag[TXR];
    assign rx_irq = cfg[RXR].mask && !flag[RXR];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr[2:0])
            OFF_BASE:  reg_rdata = DATA_W'(cfg[reg_addr[3]].base);
            OFF_COUNT: reg_rdata = DATA_W'(cfg[reg_addr[3]].count);
            OFF_EN:    reg_rdata = DATA_W'(cfg[reg_addr[3]].en);
            OFF_MASK:  reg_rdata = DATA_W'(cfg[reg_addr[3]].mask);
            OFF_FLAG:  reg_rdata = DATA_W'(flag[reg_addr[3]]);
            OFF_INDEX: reg_rdata = DATA_W'(sw_idx[reg_addr[3]]);
            default:   reg_rdata = '0;
        endcase
    end

    p_tx_halt_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg[TXR].en && !clr[TXR]) |=> ($stable(tx_fill_idx) && $stable(tx_drain_idx)));
    p_rx_halt_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg[RXR].en && !clr[RXR]) |=> $stable(rx_drain_idx));
    p_rx_write_room_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_frame && rx_room) |=> (mem_we && !rx_room));
endmodule

// File: tb/test_desc_ring_mgr.sv
module test_desc_ring_mgr;
    localparam int ADDR_W = 16, IDX_W = 4, DATA_W = 32, SIZE_W = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
    logic tx_req, tx_ack = 1'b0, rx_room, rx_frame = 1'b0, rx_err = 1'b0;
    logic [ADDR_W-1:0] tx_desc_addr, rx_desc_addr, mem_addr;
    logic [SIZE_W-1:0] rx_size = '0;
    logic mem_we, tx_irq, rx_irq;
    logic [DATA_W-1:0] mem_wdata;

    always #2 clk = ~clk;

    desc_ring_mgr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W))
    i_desc_ring_mgr (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_req(tx_req), .tx_desc_addr(tx_desc_addr), .tx_ack(tx_ack),
        .rx_room(rx_room), .rx_desc_addr(rx_desc_addr), .rx_frame(rx_frame),
        .rx_size(rx_size), .rx_err(rx_err), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    int n_cmp = 0, n_bad = 0;
    // Reference model
    int tn = 1, tp = 0, tc = 0, tpend = 0, ten = 0, tmask = 0, tbase = 0;
    int rn = 1, rp = 0, rc = 0, rpend = 0, ren = 0, rmask = 0, rbase = 0;

    function automatic int exp_addr(int base, int idx, int w);
        return base + 3 * idx + w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic chk_all(string req);
        logic [31:0] d;
        rd(4'h4, d); check({req, " tx flag"}, d, 32'(tpend == tn));
        rd(4'h5, d); check({req, " tx index"}, d, 32'(tp));
        rd(4'hC, d); check({req, " rx flag"}, d, 32'(rpend == 0));
        rd(4'hD, d); check({req, " rx index"}, d, 32'(rc));
        check({req, " tx_req"}, 32'(tx_req), 32'(ten != 0 && tpend != 0));
        check({req, " tx_desc_addr"}, 32'(tx_desc_addr), 32'(exp_addr(tbase, tc, 0)));
        check({req, " rx_room"}, 32'(rx_room), 32'(ren != 0 && rpend != rn));
        check({req, " rx_desc_addr"}, 32'(rx_desc_addr), 32'(exp_addr(rbase, rp, 0)));
        check({req, " tx_irq"}, 32'(tx_irq), 32'(tmask != 0 && tpend != tn));
        check({req, " rx_irq"}, 32'(rx_irq), 32'(rmask != 0 && rpend != 0));
    endtask

    task automatic tx_done();
        wr(4'h6, 32'hFFFF_FFFF);
        if (ten != 0 && tpend != tn) begin tp = (tp + 1) % tn; tpend++; end
    endtask

    task automatic tx_hw();
        tx_ack = 1'b1;
        @(posedge clk); #1;
        tx_ack = 1'b0;
        if (ten != 0 && tpend != 0) begin tc = (tc + 1) % tn; tpend--; end
    endtask

    task automatic rx_hw(int size, bit err);
        bit ok;
        ok = (ren != 0 && rpend != rn);
        rx_frame = 1'b1; rx_size = SIZE_W'(size); rx_err = err;
        @(posedge clk); #1;
        rx_frame = 1'b0;
        if (ok) begin
            check("R6 size we", 32'(mem_we), 32'd1);
            check("R6 size addr", 32'(mem_addr), 32'(exp_addr(rbase, rp, 1)));
            check("R6 size data", mem_wdata, 32'(size));
            check("R6 room busy", 32'(rx_room), 32'd0);
            @(posedge clk); #1;
            check("R6 stat we", 32'(mem_we), 32'd1);
            check("R6 stat addr", 32'(mem_addr), 32'(exp_addr(rbase, rp, 2)));
            check("R6 stat data", mem_wdata, 32'(2 | int'(err)));
            @(posedge clk); #1;
            rp = (rp + 1) % rn; rpend++;
        end else begin
            check("R7 frame ignored", 32'(mem_we), 32'd0);
        end
    endtask

    task automatic rx_done();
        wr(4'hE, 32'd0);
        if (ren != 0 && rpend != 0) begin rc = (rc + 1) % rn; rpend--; end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk_all("R1");
        rd(4'h2, d); check("R1 tx enable", d, 0);
        rd(4'hB, d); check("R1 rx mask", d, 0);
        rd(4'h1, d); check("R1 tx count", d, 0);

        // R10/R2/R3 configuration
        wr(4'h0, 32'h0100); tbase = 'h100;
        wr(4'h1, 32'd3);    tn = 4;
        wr(4'h8, 32'h0200); rbase = 'h200;
        wr(4'h9, 32'd2);    rn = 3;
        rd(4'h0, d); check("R10 tx base", d, 32'h100);
        rd(4'h9, d); check("R10 rx count", d, 32'd2);
        wr(4'h2, 1); ten = 1;
        wr(4'hA, 1); ren = 1;
        wr(4'h3, 1); tmask = 1;
        wr(4'hB, 1); rmask = 1;
        chk_all("R2");

        // R4 fill transmit ring, then done ignored when full
        for (int i = 0; i < 4; i++) tx_done();
        chk_all("R4 full");
        tx_done();
        chk_all("R4 ignored");
        check("R8 tx_irq low when full", 32'(tx_irq), 0);
        // R5 drain with wrap
        for (int i = 0; i < 5; i++) tx_hw();
        chk_all("R5 wrap");
        tx_done(); tx_done(); tx_hw();
        chk_all("R3 wrap addr");

        // R6/R7 receive
        rx_hw(64, 1'b0);
        rx_hw(1518, 1'b1);
        rx_hw(60, 1'b0);
        chk_all("R7 full");
        rx_hw(99, 1'b0);
        chk_all("R7 frame ignored");
        rx_done();
        rx_done(); rx_done(); rx_done();
        chk_all("R7 ignored when empty");

        // R8 mask clear
        wr(4'h3, 0); tmask = 0;
        chk_all("R8 mask off");
        wr(4'h3, 1); tmask = 1;

        // R9 disable and resume
        tx_done();
        wr(4'h2, 0); ten = 0;
        tx_done(); tx_hw();
        chk_all("R9 halted");
        wr(4'h2, 1); ten = 1;
        chk_all("R9 resume");
        tx_hw();
        chk_all("R9 resumed");

        // R3 count rewrite clears
        tx_done(); tx_done();
        wr(4'h1, 32'd5); tn = 6; tp = 0; tc = 0; tpend = 0;
        chk_all("R3 clear");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1:    begin tx_done(); chk_all("R4 rand"); end
                2, 3:    begin tx_hw();   chk_all("R5 rand"); end
                4, 5:    begin rx_hw(int'($urandom_range(60, 1518)), 1'($urandom_range(0, 1)));
                               chk_all("R6 rand"); end
                6, 7:    begin rx_done(); chk_all("R7 rand"); end
                8:       begin ten = 1 - ten; wr(4'h2, 32'(ten)); chk_all("R9 rand"); end
                default: begin rmask = 1 - rmask; wr(4'hB, 32'(rmask)); chk_all("R8 rand"); end
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule